// File: doc/BRIEF.md
# Gate-Drive Fault Supervisor

This block sits between the PWM logic of a three-phase inverter and the six gate drivers. It passes the three high-side and three low-side gate requests through while the enable input is high and no fault is present. It blocks all six of them when a fault occurs. Two sources raise a fault. One is a digitized over-current comparator flag, which is accepted only after it has stayed high for a leading-edge blanking window. The other is a supply under-voltage flag, which takes effect at once.

A fault drives the active-low fault flag low. It also raises a soft turn-off request for the low-side drivers and starts a clear timer that counts down. The fault is held until the timer has run out and the cause has gone away, whichever happens later. A new accepted over-current event during the countdown restarts the timer. The blanking window and the clear time are both counted in clock cycles and set by parameters. All outputs are registered, and reset is synchronous and active high.

Top module: `gate_fault_guard`

## Requirements
- R1: While reset is sampled high, the gate outputs are cleared. The fault is latched only if `uv_flag_i` is high during reset, and the clear timer is left idle (zero). A fault latched this way is released at the first clock edge that samples `uv_flag_i` low after reset.
- R2: If `oc_flag_i` is high for fewer than BLANK_CYCLES consecutive clock edges, it never lowers `fault_n_o`, never raises `soft_off_o` and never changes the gate outputs.
- R3: If `oc_flag_i` is high for BLANK_CYCLES consecutive edges, `fault_n_o` goes low right after the next edge (edge BLANK_CYCLES+1, counting the first edge that samples the flag high as edge 1).
- R4: The gate outputs `hi_gate_o` and `lo_gate_o` are all zero from the edge after `fault_n_o` falls. They stay zero through the edge at which `fault_n_o` is released.
- R5: An edge that samples `uv_flag_i` high drives `fault_n_o` low right after that edge. There is no blanking on this input.
- R6: The clear timer is loaded with CLEAR_CYCLES at the edge that latches the fault. If the cause has already gone, `fault_n_o` returns high right after the edge that comes CLEAR_CYCLES+1 edges after the latching edge.
- R7: If the cause is still present when the timer reaches zero, the fault stays latched. For under-voltage, the fault is released at the first edge that samples `uv_flag_i` low. For over-current, it is released one edge after the first edge that samples `oc_flag_i` low.
- R8: If a new over-current event is accepted while the fault is held, the timer is reloaded with CLEAR_CYCLES at the edge after acceptance. The release is then measured from that reload.
- R9: While `en_i` is high and no fault is present, each gate output equals its request one edge later (bit p is phase p). An edge that samples `en_i` low clears all six gate outputs.
- R10: `soft_off_o` is high exactly during the cycles in which a fault is holding the gate outputs off. While it is high, `lo_gate_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_flag_i | input | 1 | Digitized over-current comparator output |
| uv_flag_i | input | 1 | Low-side supply under-voltage flag |
| en_i | input | 1 | Filtered enable, high to run |
| hi_req_i | input | PHASES | High-side gate requests, bit p is phase p |
| lo_req_i | input | PHASES | Low-side gate requests, bit p is phase p |
| hi_gate_o | output | PHASES | Gated high-side commands |
| lo_gate_o | output | PHASES | Gated low-side commands |
| fault_n_o | output | 1 | Active-low fault flag |
| soft_off_o | output | 1 | Soft turn-off request to the low-side drivers |

## Verification
If the blanking counter is wrong, the cycle in which `fault_n_o` first falls moves. The bench sweeps the over-current pulse width across the BLANK_CYCLES boundary, so this shows up within a few cycles of each pulse. If the clear timer is wrong or is not reloaded, the release edge moves by whole cycles. The bench checks every cycle of each fault window, so a release one edge early or late is reported at the cycle where it happens. If the latch or the gating is wrong, a gate output stays high, or `soft_off_o` disagrees with the gate-off window, in the cycle right after the fault flag falls.

// File: rtl/gfg_pkg.sv
package gfg_pkg;
  typedef enum logic {TRIP_IDLE = 1'b0, TRIP_HELD = 1'b1} trip_t;

  // width of a counter that must hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/gfg_blank.sv
module gfg_blank #(
  parameter int unsigned BLANK_CYCLES = 81
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_i,
  output logic ok_o
);
  localparam int unsigned CW = gfg_pkg::cnt_w(BLANK_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(BLANK_CYCLES - 1);

  logic [CW-1:0] run_q;

  // the flag is accepted once it has been seen on BLANK_CYCLES edges in a row
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      ok_o  <= 1'b0;
    end else if (!oc_i) begin
      run_q <= '0;
      ok_o  <= 1'b0;
    end else if (run_q == LAST) begin
      ok_o  <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
      ok_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/gfg_latch.sv
module gfg_latch #(
  parameter int unsigned CLEAR_CYCLES = 225000
) (
  input  logic clk,
  input  logic rst,
  input  logic ok_i,
  input  logic uv_i,
  output logic fault_o
);
  import gfg_pkg::*;
  localparam int unsigned TW = cnt_w(CLEAR_CYCLES);
  localparam logic [TW-1:0] LOAD = TW'(CLEAR_CYCLES);

  trip_t         st_q;
  logic [TW-1:0] tmr_q;
  logic          ok_prev_q;
  logic          cause;
  logic          oc_new;

  assign cause  = ok_i | uv_i;
  assign oc_new = ok_i & ~ok_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= uv_i ? TRIP_HELD : TRIP_IDLE;
      tmr_q     <= '0;
      ok_prev_q <= 1'b0;
    end else begin
      ok_prev_q <= ok_i;
      unique case (st_q)
        TRIP_IDLE: begin
          if (cause) begin
            st_q  <= TRIP_HELD;
            tmr_q <= LOAD;
          end
        end
        TRIP_HELD: begin
          if (oc_new) begin
            tmr_q <= LOAD;
          end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end
          if (!cause && tmr_q == '0) begin
            st_q <= TRIP_IDLE;
          end
        end
        default: st_q <= TRIP_HELD;
      endcase
    end
  end

  assign fault_o = (st_q == TRIP_HELD);
endmodule

// File: rtl/gfg_gate.sv
module gfg_gate #(
  parameter int unsigned PHASES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              fault_i,
  input  logic [PHASES-1:0] hi_req_i,
  input  logic [PHASES-1:0] lo_req_i,
  output logic [PHASES-1:0] hi_gate_o,
  output logic [PHASES-1:0] lo_gate_o,
  output logic              soft_off_o
);
  logic pass;
  assign pass = en_i & ~fault_i;

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_gate_o[p] <= 1'b0;
        lo_gate_o[p] <= 1'b0;
      end else begin
        hi_gate_o[p] <= hi_req_i[p] & pass;
        lo_gate_o[p] <= lo_req_i[p] & pass;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) soft_off_o <= 1'b0;
    else     soft_off_o <= fault_i;
  end
endmodule

// File: rtl/gate_fault_guard.sv
module gate_fault_guard #(
  parameter int unsigned PHASES       = 3,
  parameter int unsigned BLANK_CYCLES = 81,
  parameter int unsigned CLEAR_CYCLES = 225000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oc_flag_i,
  input  logic              uv_flag_i,
  input  logic              en_i,
  input  logic [PHASES-1:0] hi_req_i,
  input  logic [PHASES-1:0] lo_req_i,
  output logic [PHASES-1:0] hi_gate_o,
  output logic [PHASES-1:0] lo_gate_o,
  output logic              fault_n_o,
  output logic              soft_off_o
);
  logic oc_ok;
  logic fault;

  gfg_blank #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk  (clk),
    .rst  (rst),
    .oc_i (oc_flag_i),
    .ok_o (oc_ok)
  );

  gfg_latch #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .ok_i    (oc_ok),
    .uv_i    (uv_flag_i),
    .fault_o (fault)
  );

  gfg_gate #(.PHASES(PHASES)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .fault_i    (fault),
    .hi_req_i   (hi_req_i),
    .lo_req_i   (lo_req_i),
    .hi_gate_o  (hi_gate_o),
    .lo_gate_o  (lo_gate_o),
    .soft_off_o (soft_off_o)
  );

  assign fault_n_o = ~fault;
endmodule

// File: rtl/gfg_checker.sv
module gfg_checker #(
  parameter int unsigned PHASES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              uv_flag_i,
  input logic              en_i,
  input logic [PHASES-1:0] hi_gate_o,
  input logic [PHASES-1:0] lo_gate_o,
  input logic              fault_n_o,
  input logic              soft_off_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (hi_gate_o == '0 && lo_gate_o == '0));

  a_r4_fault_blocks: assert property (@(posedge clk) disable iff (rst)
    !fault_n_o |=> (hi_gate_o == '0 && lo_gate_o == '0));

  a_r5_uv_trips: assert property (@(posedge clk) disable iff (rst)
    uv_flag_i |=> !fault_n_o);

  a_r6_min_hold: assert property (@(posedge clk) disable iff (rst)
    ($fell(fault_n_o) && !$past(rst)) |=> !fault_n_o);

  a_r9_enable_off: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (hi_gate_o == '0 && lo_gate_o == '0));

  a_r10_soft_low_off: assert property (@(posedge clk) disable iff (rst)
    soft_off_o |-> (lo_gate_o == '0));
endmodule

bind gate_fault_guard gfg_checker #(.PHASES(PHASES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .uv_flag_i  (uv_flag_i),
  .en_i       (en_i),
  .hi_gate_o  (hi_gate_o),
  .lo_gate_o  (lo_gate_o),
  .fault_n_o  (fault_n_o),
  .soft_off_o (soft_off_o)
);

// File: tb/sim_gate_fault_guard.sv
`timescale 1ns/1ps
module sim_gate_fault_guard;
  localparam int B = 4;
  localparam int C = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       oc = 1'b0, uv = 1'b0, en = 1'b0;
  logic [2:0] hi_req = '0, lo_req = '0;
  logic [2:0] hi_gate, lo_gate;
  logic       fault_n, soft_off;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gate_fault_guard #(.PHASES(3), .BLANK_CYCLES(B), .CLEAR_CYCLES(C)) u0 (
    .clk(clk), .rst(rst), .oc_flag_i(oc), .uv_flag_i(uv), .en_i(en),
    .hi_req_i(hi_req), .lo_req_i(lo_req), .hi_gate_o(hi_gate),
    .lo_gate_o(lo_gate), .fault_n_o(fault_n), .soft_off_o(soft_off)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000 && !done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step();
    step();
    step();
    rst = 1'b0;
    step();
    // R1: reset state with no under-voltage
    chk("R1 fault_n", fault_n, 1);
    chk("R1 gates", {hi_gate, lo_gate}, 0);
    chk("R1 soft_off", soft_off, 0);

    // R9: pass-through sweep over all request patterns
    en = 1'b1;
    for (int v = 0; v < 64; v++) begin
      hi_req = v[2:0];
      lo_req = v[5:3];
      step();
      chk("R9 hi", hi_gate, v & 7);
      chk("R9 lo", lo_gate, (v >> 3) & 7);
    end
    hi_req = 3'b111;
    lo_req = 3'b111;
    en = 1'b0;
    step();
    chk("R9 enable low", {hi_gate, lo_gate}, 0);
    en = 1'b1;
    step();
    step();

    // R2/R3/R4/R6/R10: sweep of over-current pulse width across the window
    for (int w = 1; w <= B + 2; w++) begin
      for (int k = 1; k <= B + C + 6; k++) begin
        int ef, eg, es;
        bit trip;
        oc = (k <= w);
        step();
        trip = (w >= B);
        ef = (trip && k >= B + 1 && k <= B + C + 1) ? 0 : 1;
        eg = (trip && k >= B + 2 && k <= B + C + 2) ? 0 : 7;
        es = (trip && k >= B + 2 && k <= B + C + 2) ? 1 : 0;
        if (k == B + C + 2) chk("R6 release", fault_n, ef);
        else chk(trip ? "R3 fault_n" : "R2 fault_n", fault_n, ef);
        chk("R4 hi", hi_gate, eg);
        chk("R4 lo", lo_gate, eg);
        chk("R10 soft_off", soft_off, es);
      end
      oc = 1'b0;
      step();
      step();
    end

    // R7: over-current held past the timer
    begin
      int h;
      h = B + C + 10;
      for (int k = 1; k <= h + 3; k++) begin
        oc = (k <= h);
        step();
        chk("R7 oc persist", fault_n, (k >= B + 1 && k <= h + 1) ? 0 : 1);
      end
    end
    step();

    // R8: second accepted event reloads the timer
    for (int k = 1; k <= 2 * B + C + 9; k++) begin
      oc = (k <= B) || (k >= B + 6 && k <= 2 * B + 5);
      step();
      chk("R8 reload", fault_n, (k >= B + 1 && k <= 2 * B + C + 6) ? 0 : 1);
    end
    oc = 1'b0;
    step();

    // R5/R6: short under-voltage, no blanking
    for (int k = 1; k <= C + 4; k++) begin
      uv = (k <= 3);
      step();
      chk(k == 1 ? "R5 uv immediate" : "R6 uv timer", fault_n, (k <= C + 1) ? 0 : 1);
    end
    step();

    // R7: under-voltage held past the timer
    for (int k = 1; k <= C + 8; k++) begin
      uv = (k <= C + 5);
      step();
      chk("R7 uv persist", fault_n, (k <= C + 5) ? 0 : 1);
    end
    step();

    // R1: reset with under-voltage present, timer idle
    rst = 1'b1;
    uv = 1'b1;
    step();
    step();
    rst = 1'b0;
    step();
    chk("R1 uv reset fault_n", fault_n, 0);
    chk("R1 uv reset gates", {hi_gate, lo_gate}, 0);
    uv = 1'b0;
    step();
    chk("R1 idle timer release", fault_n, 1);
    step();
    chk("R1 gates resume", {hi_gate, lo_gate}, 63);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule